// File: doc/BRIEF.md
# Post-modify cursor address generator

This block sits between a CPU-side bus slave and a pixel-memory bus master, both using Wishbone-style cycle, strobe and acknowledge signalling. It keeps a cursor that points into pixel memory and a small table of signed step values. When the CPU accesses pixel memory through this block, the access goes to the address held in the cursor. The slave address picks one step entry, and when the pixel access completes that entry is added to the cursor. Relative walks such as "next pixel" or "one row up" therefore cost no extra bus cycles.

The CPU reaches the cursor, the step table and an extension register through dedicated strobes. The step values and the cursor can be wider than the data bus. The extension register then carries the bits above the bus width in both directions. A wide value is built by writing the extension register first and the low part second. It is read back by reading the low part, which copies the upper bits into the extension register, and then reading the extension register.

Top module: `postmod_cursor`

## Requirements
- R1: After reset the cursor and the extension register read back as zero. `s_ack`, `m_cyc` and `m_stb` are low.
- R2: A write on `s_cur_stb` loads the cursor with {extension, low data bits}. A read on `s_cur_stb` returns the low `DW` cursor bits and copies the cursor bits above `DW` into the extension register.
- R3: A write on `s_ext_stb` loads the extension register from data bits `[VA_W-DW-1:0]`; higher data bits are dropped. A read on `s_ext_stb` returns the extension register, zero-extended.
- R4: A write on `s_inc_stb` stores {extension, low data bits} into step entry `s_adr`. A read returns the entry's low `DW` bits and copies its upper bits into the extension register. Neither access moves the cursor.
- R5: A write on `s_pix_stb` runs one master cycle with `m_we` = 1 at address `m_adr` equal to the cursor. `s_wdata` is passed to `m_wdata` and `s_sel` to `m_sel` unchanged.
- R6: A read on `s_pix_stb` runs one master cycle with `m_we` = 0. The slave returns `m_rdata`, as sampled at the master acknowledge, on `s_rdata` together with `s_ack`.
- R7: At the clock edge that samples `m_ack`, the cursor becomes (cursor + entry[`s_adr`]) modulo 2^`VA_W`, so negative entries step backwards and both directions wrap. The cursor does not change while the master waits.
- R8: For a pixel access, `s_ack` is high in the cycle after `m_ack`. A request with W master wait states therefore completes W+2 cycles after it is presented, and `m_adr` stays stable while the master waits.
- R9: A cursor, extension or step-table access is acknowledged in the cycle after it is presented. `s_ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_cyc | input | 1 | Slave bus cycle |
| s_cur_stb | input | 1 | Strobe for the cursor |
| s_ext_stb | input | 1 | Strobe for the extension register |
| s_inc_stb | input | 1 | Strobe for the step table |
| s_pix_stb | input | 1 | Strobe for a post-modified pixel access |
| s_we | input | 1 | Slave write enable |
| s_adr | input | ADR_W | Step table entry select |
| s_sel | input | DW/8 | Slave byte selects |
| s_wdata | input | DW | Slave write data |
| s_rdata | output | DW | Slave read data |
| s_ack | output | 1 | Slave acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master strobe |
| m_we | output | 1 | Master write enable |
| m_adr | output | VA_W | Pixel memory address (cursor) |
| m_sel | output | DW/8 | Master byte selects |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Master read data |
| m_ack | input | 1 | Master acknowledge |

## Verification
A register-side result (`s_ack`, `s_rdata`, and the new cursor, extension or entry) is due at the first clock edge after the request is driven. A pixel-side result is due W+2 edges after the request, where W is the number of wait states the bench memory inserts before raising `m_ack`. The bench drives each request on a falling edge and counts rising edges until it sees `s_ack`, sampling 1 ns after each edge. It compares that count with 1 or W+2 and reads the data only at that point. Cursor movement is read back through the cursor and extension strobes, and the memory model records the address, byte selects and write flag it saw at its acknowledge.

// File: rtl/postmod_pkg.sv
package postmod_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CUR,
    ACC_EXT,
    ACC_INC,
    ACC_PIX
  } acc_kind_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_BUSY
  } seq_state_e;

endpackage

// File: rtl/postmod_incr_ram.sv
module postmod_incr_ram #(
  parameter int ADR_W = 3,
  parameter int VA_W  = 20
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_adr,
  input  logic [VA_W-1:0]  wr_val,
  input  logic [ADR_W-1:0] rd_adr,
  output logic [VA_W-1:0]  rd_val
);
  localparam int DEPTH = 1 << ADR_W;

  logic [VA_W-1:0] ent_q [DEPTH];

  // storage array without reset, written one entry per cycle
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_adr] <= wr_val;
    end
  end

  assign rd_val = ent_q[rd_adr];

endmodule

// File: rtl/postmod_pix_seq.sv
module postmod_pix_seq import postmod_pkg::*; #(
  parameter int VA_W  = 20,
  parameter int DW    = 16,
  parameter int SEL_W = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             s_we,
  input  logic [SEL_W-1:0] s_sel,
  input  logic [DW-1:0]    s_wdata,
  input  logic [VA_W-1:0]  cursor,
  output logic             m_cyc,
  output logic             m_stb,
  output logic             m_we,
  output logic [VA_W-1:0]  m_adr,
  output logic [SEL_W-1:0] m_sel,
  output logic [DW-1:0]    m_wdata,
  input  logic             m_ack,
  output logic             done
);
  seq_state_e state_q, state_d;
  logic       busy;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_BUSY;
      SEQ_BUSY: if (m_ack) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy    = (state_q == SEQ_BUSY);
  assign done    = busy & m_ack;
  assign m_cyc   = busy;
  assign m_stb   = busy;
  assign m_we    = busy & s_we;
  assign m_adr   = cursor;
  assign m_sel   = s_sel;
  assign m_wdata = s_wdata;

  AST_MADR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stb && !m_ack) |=> $stable(m_adr)); // R8

  AST_MSTB_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_stb) |-> $past(start)); // R5

endmodule

// File: rtl/postmod_cursor.sv
module postmod_cursor import postmod_pkg::*; #(
  parameter int ADR_W = 3,
  parameter int VA_W  = 20,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_cyc,
  input  logic                s_cur_stb,
  input  logic                s_ext_stb,
  input  logic                s_inc_stb,
  input  logic                s_pix_stb,
  input  logic                s_we,
  input  logic [ADR_W-1:0]    s_adr,
  input  logic [DW/8-1:0]     s_sel,
  input  logic [DW-1:0]       s_wdata,
  output logic [DW-1:0]       s_rdata,
  output logic                s_ack,
  output logic                m_cyc,
  output logic                m_stb,
  output logic                m_we,
  output logic [VA_W-1:0]     m_adr,
  output logic [DW/8-1:0]     m_sel,
  output logic [DW-1:0]       m_wdata,
  input  logic [DW-1:0]       m_rdata,
  input  logic                m_ack
);
  localparam int SEL_W   = DW / 8;
  localparam int HAS_EXT = (VA_W > DW) ? 1 : 0;
  localparam int EXT_W   = (HAS_EXT != 0) ? VA_W - DW : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // strobe decode, pixel access has priority
  acc_kind_e kind;
  logic      ack_q, ack_d;
  logic      reg_go, pix_start, pix_done;
  logic      cur_wr, cur_rd, ext_wr, inc_wr, inc_rd;

  always_comb begin
    kind = ACC_NONE;
    if (s_cyc) begin
      if (s_pix_stb)      kind = ACC_PIX;
      else if (s_cur_stb) kind = ACC_CUR;
      else if (s_inc_stb) kind = ACC_INC;
      else if (s_ext_stb) kind = ACC_EXT;
    end
  end

  assign reg_go    = (kind inside {ACC_CUR, ACC_EXT, ACC_INC}) && !ack_q;
  assign pix_start = (kind == ACC_PIX) && !ack_q;
  assign cur_wr    = reg_go && (kind == ACC_CUR) && s_we;
  assign cur_rd    = reg_go && (kind == ACC_CUR) && !s_we;
  assign ext_wr    = reg_go && (kind == ACC_EXT) && s_we;
  assign inc_wr    = reg_go && (kind == ACC_INC) && s_we;
  assign inc_rd    = reg_go && (kind == ACC_INC) && !s_we;

  logic [VA_W-1:0] cursor_q, cursor_d, inc_val, wide_wr;
  logic            cursor_en;
  logic [DW-1:0]   cur_lo, inc_lo, ext_rd;

  postmod_incr_ram #(.ADR_W(ADR_W), .VA_W(VA_W)) i_incr_ram (
    .clk    (clk),
    .wr_en  (inc_wr),
    .wr_adr (s_adr),
    .wr_val (wide_wr),
    .rd_adr (s_adr),
    .rd_val (inc_val)
  );

  postmod_pix_seq #(.VA_W(VA_W), .DW(DW), .SEL_W(SEL_W)) i_pix_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (pix_start),
    .s_we    (s_we),
    .s_sel   (s_sel),
    .s_wdata (s_wdata),
    .cursor  (cursor_q),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_we    (m_we),
    .m_adr   (m_adr),
    .m_sel   (m_sel),
    .m_wdata (m_wdata),
    .m_ack   (m_ack),
    .done    (pix_done)
  );

  // extension register exists only when values outgrow the data bus
  if (HAS_EXT != 0) begin : g_ext
    logic [EXT_W-1:0] ext_q, ext_d;
    logic             ext_en;

    always_comb begin
      ext_en = 1'b1;
      ext_d  = ext_q;
      if (ext_wr)      ext_d = s_wdata[EXT_W-1:0];
      else if (cur_rd) ext_d = cursor_q[VA_W-1:DW];
      else if (inc_rd) ext_d = inc_val[VA_W-1:DW];
      else             ext_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        ext_q <= '0;
      end else if (ext_en) begin
        ext_q <= ext_d;
      end
    end

    assign wide_wr = {ext_q, s_wdata};
    assign cur_lo  = cursor_q[DW-1:0];
    assign inc_lo  = inc_val[DW-1:0];
    assign ext_rd  = DW'(ext_q);
  end else begin : g_no_ext
    assign wide_wr = s_wdata[VA_W-1:0];
    assign cur_lo  = DW'(cursor_q);
    assign inc_lo  = DW'(inc_val);
    assign ext_rd  = '0;
  end

  // cursor: post-modify on master acknowledge, or direct load
  always_comb begin
    cursor_en = pix_done | cur_wr;
    cursor_d  = pix_done ? cursor_q + inc_val : wide_wr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cursor_q <= '0;
    end else if (cursor_en) begin
      cursor_q <= cursor_d;
    end
  end

  // slave acknowledge and read data
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_en;

  assign ack_d = reg_go | pix_done;

  always_comb begin
    rdata_en = ack_d && !s_we;
    case (kind)
      ACC_PIX: rdata_d = m_rdata;
      ACC_CUR: rdata_d = cur_lo;
      ACC_EXT: rdata_d = ext_rd;
      ACC_INC: rdata_d = inc_lo;
      default: rdata_d = rdata_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (rdata_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign s_ack   = ack_q;
  assign s_rdata = rdata_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    s_ack |=> !s_ack); // R9

  AST_REG_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_go |=> s_ack); // R9

  AST_PIX_ACK_AFTER_MACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s_ack && s_cyc && s_pix_stb) |-> $past(m_ack)); // R8

  AST_CURSOR_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_stb && !m_ack) |=> $stable(cursor_q)); // R7

  AST_TABLE_KEEPS_CURSOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s_cyc && s_inc_stb && !s_pix_stb && !s_cur_stb) |=> $stable(cursor_q)); // R4

endmodule

// File: tb/test_postmod_cursor.sv
module test_postmod_cursor;
  localparam int ADR_W = 3;
  localparam int VA_W  = 20;
  localparam int DW    = 16;
  localparam int SEL_W = DW / 8;
  localparam int EXT_W = VA_W - DW;
  localparam int K_CUR = 0, K_EXT = 1, K_INC = 2, K_PIX = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             s_cyc, s_cur_stb, s_ext_stb, s_inc_stb, s_pix_stb, s_we;
  logic [ADR_W-1:0] s_adr;
  logic [SEL_W-1:0] s_sel;
  logic [DW-1:0]    s_wdata, s_rdata;
  logic             s_ack;
  logic             m_cyc, m_stb, m_we, m_ack;
  logic [VA_W-1:0]  m_adr;
  logic [SEL_W-1:0] m_sel;
  logic [DW-1:0]    m_wdata, m_rdata;

  postmod_cursor #(.ADR_W(ADR_W), .VA_W(VA_W), .DW(DW)) i_postmod_cursor (
    .clk(clk), .rst_n(rst_n), .s_cyc(s_cyc), .s_cur_stb(s_cur_stb),
    .s_ext_stb(s_ext_stb), .s_inc_stb(s_inc_stb), .s_pix_stb(s_pix_stb),
    .s_we(s_we), .s_adr(s_adr), .s_sel(s_sel), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ack(s_ack), .m_cyc(m_cyc), .m_stb(m_stb),
    .m_we(m_we), .m_adr(m_adr), .m_sel(m_sel), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack)
  );

  // pixel memory model with programmable wait states
  logic [DW-1:0]    mem [256];
  int               mwait = 0;
  int               wcnt = 0;
  logic [VA_W-1:0]  seen_adr = '0;
  logic [SEL_W-1:0] seen_sel = '0;
  logic             seen_we = 1'b0;

  assign m_ack   = m_cyc && m_stb && (wcnt == mwait);
  assign m_rdata = mem[m_adr[7:0]];

  always @(posedge clk) begin
    if (m_stb && !m_ack) wcnt <= wcnt + 1;
    else                 wcnt <= 0;
    if (m_ack) begin
      seen_adr <= m_adr;
      seen_sel <= m_sel;
      seen_we  <= m_we;
      if (m_we) mem[m_adr[7:0]] <= m_wdata;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input int kind, input logic we, input logic [ADR_W-1:0] adr,
                        input logic [DW-1:0] d, input logic [SEL_W-1:0] sel,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    s_cyc = 1'b1; s_we = we; s_adr = adr; s_wdata = d; s_sel = sel;
    s_cur_stb = (kind == K_CUR); s_ext_stb = (kind == K_EXT);
    s_inc_stb = (kind == K_INC); s_pix_stb = (kind == K_PIX);
    cyc = 0;
    do begin
      @(posedge clk); #1;
      cyc++;
    end while (!s_ack && cyc < 100);
    rd = s_rdata;
    s_cyc = 1'b0; s_cur_stb = 1'b0; s_ext_stb = 1'b0; s_inc_stb = 1'b0;
    s_pix_stb = 1'b0; s_we = 1'b0;
    @(posedge clk);
  endtask

  task automatic wr(input int kind, input logic [ADR_W-1:0] adr, input logic [DW-1:0] d);
    logic [DW-1:0] rd;
    int c;
    access(kind, 1'b1, adr, d, '1, rd, c);
  endtask

  task automatic rdv(input int kind, input logic [ADR_W-1:0] adr, output logic [DW-1:0] v);
    int c;
    access(kind, 1'b0, adr, '0, '1, v, c);
  endtask

  task automatic get_cursor(output logic [VA_W-1:0] v);
    logic [DW-1:0] lo, hi;
    rdv(K_CUR, '0, lo);
    rdv(K_EXT, '0, hi);
    v = {hi[EXT_W-1:0], lo};
  endtask

  task automatic set_cursor(input logic [VA_W-1:0] v);
    wr(K_EXT, '0, DW'(v[VA_W-1:DW]));
    wr(K_CUR, '0, v[DW-1:0]);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    logic [VA_W-1:0] c;
    check("R1 s_ack after reset", 32'(s_ack), 32'h0);
    check("R1 m_cyc after reset", 32'(m_cyc), 32'h0);
    check("R1 m_stb after reset", 32'(m_stb), 32'h0);
    rdv(K_EXT, '0, v);
    check("R1 extension after reset", 32'(v), 32'h0);
    get_cursor(c);
    check("R1 cursor after reset", 32'(c), 32'h0);
  endtask

  task automatic t_regs;
    logic [DW-1:0] v;
    int c;
    wr(K_EXT, '0, 16'h000A);
    access(K_CUR, 1'b1, '0, 16'h1234, '1, v, c);
    check("R9 register ack latency", 32'(c), 32'd1);
    wr(K_EXT, '0, 16'h0003);
    rdv(K_CUR, '0, v);
    check("R2 cursor low bits", 32'(v), 32'h1234);
    rdv(K_EXT, '0, v);
    check("R2 cursor upper bits via extension", 32'(v), 32'hA);
    wr(K_EXT, '0, 16'hFFF5);
    rdv(K_EXT, '0, v);
    check("R3 extension truncated write", 32'(v), 32'h5);
  endtask

  task automatic t_table;
    logic [DW-1:0] v;
    logic [VA_W-1:0] c;
    set_cursor(20'h00777);
    wr(K_EXT, '0, 16'h000F); wr(K_INC, 3'd3, 16'hFFC0);
    wr(K_EXT, '0, 16'h0000); wr(K_INC, 3'd2, 16'h0040);
    wr(K_EXT, '0, 16'h0000); wr(K_INC, 3'd0, 16'h0001);
    wr(K_EXT, '0, 16'h000F); wr(K_INC, 3'd1, 16'hFFFF);
    wr(K_EXT, '0, 16'h0000);
    rdv(K_INC, 3'd3, v);
    check("R4 entry low bits", 32'(v), 32'hFFC0);
    rdv(K_EXT, '0, v);
    check("R4 entry upper bits via extension", 32'(v), 32'hF);
    get_cursor(c);
    check("R4 table access leaves cursor", 32'(c), 32'h00777);
  endtask

  task automatic t_pix_write;
    logic [DW-1:0] v;
    logic [VA_W-1:0] c;
    int n;
    mwait = 0;
    set_cursor(20'h00010);
    access(K_PIX, 1'b1, 3'd0, 16'hBEEF, 2'b10, v, n);
    check("R8 pixel latency zero waits", 32'(n), 32'd2);
    check("R5 memory data", 32'(mem[8'h10]), 32'hBEEF);
    check("R5 master address is cursor", 32'(seen_adr), 32'h00010);
    check("R5 byte selects passed", 32'(seen_sel), 32'h2);
    check("R5 master write flag", 32'(seen_we), 32'h1);
    check("R8 master idle after access", 32'(m_cyc), 32'h0);
    get_cursor(c);
    check("R7 cursor after +1 step", 32'(c), 32'h00011);
    access(K_PIX, 1'b1, 3'd3, 16'h5A5A, 2'b11, v, n);
    get_cursor(c);
    check("R7 negative step wraps below zero", 32'(c), 32'hFFFD1);
  endtask

  task automatic t_pix_read;
    logic [DW-1:0] v;
    logic [VA_W-1:0] c;
    int n;
    mwait = 3;
    set_cursor(20'h00011);
    access(K_PIX, 1'b0, 3'd1, 16'h0000, 2'b11, v, n);
    check("R6 pixel read data", 32'(v), 32'h5A5A);
    check("R6 master read flag", 32'(seen_we), 32'h0);
    check("R8 pixel latency three waits", 32'(n), 32'd5);
    get_cursor(c);
    check("R7 cursor after -1 step", 32'(c), 32'h00010);
    mwait = 1;
    access(K_PIX, 1'b0, 3'd2, 16'h0000, 2'b11, v, n);
    check("R6 read of earlier write", 32'(v), 32'hBEEF);
    check("R8 pixel latency one wait", 32'(n), 32'd3);
    get_cursor(c);
    check("R7 cursor after row step", 32'(c), 32'h00050);
  endtask

  task automatic t_wrap_up;
    logic [DW-1:0] v;
    logic [VA_W-1:0] c;
    int n;
    mwait = 0;
    set_cursor(20'hFFFFF);
    access(K_PIX, 1'b1, 3'd0, 16'h1111, 2'b01, v, n);
    check("R5 top address reached", 32'(seen_adr), 32'hFFFFF);
    get_cursor(c);
    check("R7 cursor wraps to zero", 32'(c), 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    s_cyc = 1'b0; s_cur_stb = 1'b0; s_ext_stb = 1'b0; s_inc_stb = 1'b0;
    s_pix_stb = 1'b0; s_we = 1'b0; s_adr = '0; s_sel = '0; s_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_regs();
    t_table();
    t_pix_write();
    t_pix_read();
    t_wrap_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule